// File: doc/BRIEF.md
# Coprocessor Port and Handshake Unit

This block is the host-facing side of a numeric coprocessor. The host reaches it through four word ports, chosen by a 2-bit port index, in bus cycles that count only when both select inputs are high in the same clock. The host writes an opcode, reads back a 16-bit status word that tells it how to proceed, writes an exception pointer, and then moves operand or result words through a four-entry FIFO. Three handshake outputs tell the host what to do: busy, operand request and error.

The execution core is a stub. It runs for a number of cycles given in the opcode, then produces result words or raises an exception. Opcode decoding is a small lookup on the opcode's class field. Operand words and result words pass only through the data port. The block has no path to memory of its own.

Top module: `cop_port_unit`

## Requirements
- R1: An access takes effect only when sel_a_i and sel_b_i are both high in the same cycle. With only one select high, a write has no effect.
- R2: A write to port 0 (opcode) is accepted in every state, including while busy_o or error_o is high. If the unit is busy, the new opcode waits and starts once the current operation has finished. Port 3 always returns the status of the most recently written opcode.
- R3: Opcode bits 13:12 give the class: 0 plain, 1 load, 2 store, 3 clear-exception. Bits 7:4 plus one give the execution length L. Bits 1:0 plus one give the word count N. Bit 8 requests an exception.
- R4: The status word read at port 3 is built as follows. Bit 0 means wait for not-busy and is set for every class except clear. Bit 1 means a pointer write is needed and is set for load and store. Bit 2 means results flow from the coprocessor to the host and is set for store. Bits 7:4 hold N for load and store and are 0 otherwise. All other bits are 0. After reset the status reads 16'h0001.
- R5: busy_o rises in the cycle after an opcode write. For a plain opcode written while idle, busy_o stays high for exactly L+1 cycles.
- R6: A load opcode neither executes nor raises pereq_o until the host writes port 2 (exception pointer). After that write, pereq_o stays high until N words have been written to port 1. Execution then runs and busy_o falls.
- R7: A store opcode executes after the pointer write. It then offers N result words at port 1, word i (counting from 0) being pointer+i. pereq_o is high while unread words remain. Each read pops one word, in order. busy_o falls after the last read.
- R8: An opcode with bit 8 set raises error_o when its execution ends. error_o stays high through later opcodes until a clear-exception opcode is taken.
- R9: The FIFO never holds more than 4 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_a_i | input | 1 | First select, active high |
| sel_b_i | input | 1 | Second select, active high |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| port_i | input | 2 | Port: 0 opcode, 1 data, 2 pointer, 3 status |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data: status or FIFO head |
| busy_o | output | 1 | Operation pending or in progress |
| pereq_o | output | 1 | FIFO ready for an operand transfer |
| error_o | output | 1 | Exception pending |

## Verification
Two functions can fall in the same cycle: an opcode write landing while a store is still handing out results, and the data-port pops of that same store. The bench provokes this by writing a plain opcode between two result reads of a draining store. It then checks that the remaining results come out unchanged and in order. It also checks that the status port already reflects the new opcode, and that the new opcode keeps busy_o high and runs only after the FIFO has emptied.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int unsigned DW = 16;

  typedef enum logic [1:0] {
    P_OP   = 2'd0,
    P_DATA = 2'd1,
    P_PTR  = 2'd2,
    P_STAT = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    C_PLAIN = 2'd0,
    C_LOAD  = 2'd1,
    C_STORE = 2'd2,
    C_CLEAR = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WPTR, S_FILL, S_EXEC, S_PUSH, S_DRAIN
  } state_e;
endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_pkg::*;
(
  input  logic [DW-1:0] op_i,
  output op_class_e     cls_o,
  output logic [4:0]    len_o,
  output logic [2:0]    cnt_o,
  output logic          exc_o,
  output logic [DW-1:0] status_o
);
  always_comb begin
    cls_o = op_class_e'(op_i[13:12]);
    len_o = {1'b0, op_i[7:4]} + 5'd1;
    cnt_o = {1'b0, op_i[1:0]} + 3'd1;
    exc_o = op_i[8];
    status_o = '0;
    status_o[0] = (cls_o != C_CLEAR);
    status_o[1] = (cls_o == C_LOAD) || (cls_o == C_STORE);
    status_o[2] = (cls_o == C_STORE);
    if (status_o[1]) status_o[7:4] = {1'b0, cnt_o};
  end
endmodule

// File: rtl/cop_fifo.sv
module cop_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_o == CW'(DEPTH));
  assign empty_o = (cnt_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_o <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_o <= '0;
    end else begin
      if (do_push) wp_q <= inc(wp_q);
      if (do_pop)  rp_q <= inc(rp_q);
      cnt_o <= cnt_o + CW'(do_push) - CW'(do_pop);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (do_push && !flush_i && wp_q == AW'(g)) mem_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/cop_exec_stub.sv
module cop_exec_stub #(
  parameter int unsigned LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic          done_o
);
  logic [LW-1:0] cnt_q;
  logic          run_q;

  assign done_o = run_q && (cnt_q == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= len_i; run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q - LW'(1);
      if (done_o) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cop_port_unit.sv
module cop_port_unit
  import cop_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_a_i,
  input  logic          sel_b_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    port_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic          busy_o,
  output logic          pereq_o,
  output logic          error_o
);
  state_e        st_q;
  logic [DW-1:0] nxt_q, cur_q, ptr_q;
  logic          pend_q, err_q;
  logic [2:0]    got_q, idx_q;

  op_class_e     n_cls, c_cls;
  logic [4:0]    n_len, c_len;
  logic [2:0]    n_cnt, c_cnt;
  logic          n_exc, c_exc;
  logic [DW-1:0] n_stat, c_stat;

  logic          acc, wr_op, wr_dat, wr_ptr, rd_dat;
  logic          take, push, pop, flush, ex_start, ex_done, last_in;
  logic [DW-1:0] push_data, head;
  logic [CW-1:0] fifo_cnt;
  logic          full, empty;

  cop_decode u_dec_nxt (.op_i(nxt_q), .cls_o(n_cls), .len_o(n_len),
                        .cnt_o(n_cnt), .exc_o(n_exc), .status_o(n_stat));
  cop_decode u_dec_cur (.op_i(cur_q), .cls_o(c_cls), .len_o(c_len),
                        .cnt_o(c_cnt), .exc_o(c_exc), .status_o(c_stat));

  // both selects in the same clock qualify a bus cycle
  assign acc    = sel_a_i && sel_b_i;
  assign wr_op  = acc && wr_i && (port_i == P_OP);
  assign wr_dat = acc && wr_i && (port_i == P_DATA);
  assign wr_ptr = acc && wr_i && (port_i == P_PTR);
  assign rd_dat = acc && rd_i && (port_i == P_DATA);

  assign take    = (st_q == S_IDLE) && pend_q;
  assign pereq_o = ((st_q == S_FILL) && !full) || ((st_q == S_DRAIN) && !empty);
  assign push    = ((st_q == S_FILL) && wr_dat && !full) || (st_q == S_PUSH);
  assign pop     = (st_q == S_DRAIN) && rd_dat && !empty;
  assign last_in = (got_q + 3'd1) == c_cnt;
  assign flush   = (st_q == S_EXEC) && ex_done && (c_cls == C_LOAD);
  assign push_data = (st_q == S_PUSH) ? ptr_q + DW'(idx_q) : wdata_i;

  assign ex_start = (take && n_cls == C_PLAIN)
                 || ((st_q == S_WPTR) && wr_ptr && c_cls == C_STORE)
                 || ((st_q == S_FILL) && push && last_in);

  cop_exec_stub #(.LW(5)) u_exec (
    .clk_i, .rst_ni, .start_i(ex_start),
    .len_i(take ? n_len : c_len), .done_o(ex_done)
  );

  cop_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(push), .wdata_i(push_data),
    .pop_i(pop), .rdata_o(head), .cnt_o(fifo_cnt), .full_o(full), .empty_o(empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; nxt_q <= '0; cur_q <= '0; ptr_q <= '0;
      pend_q <= 1'b0; err_q <= 1'b0; got_q <= '0; idx_q <= '0;
    end else begin
      if (wr_op)  nxt_q <= wdata_i;
      if (wr_ptr) ptr_q <= wdata_i;
      if (wr_op)     pend_q <= 1'b1;
      else if (take) pend_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (pend_q) begin
          cur_q <= nxt_q;
          unique case (n_cls)
            C_CLEAR: err_q <= 1'b0;
            C_PLAIN: st_q  <= S_EXEC;
            default: st_q  <= S_WPTR;
          endcase
        end
        S_WPTR: if (wr_ptr) begin
          got_q <= '0;
          st_q  <= (c_cls == C_LOAD) ? S_FILL : S_EXEC;
        end
        S_FILL: if (push) begin
          got_q <= got_q + 3'd1;
          if (last_in) st_q <= S_EXEC;
        end
        S_EXEC: if (ex_done) begin
          if (c_exc) err_q <= 1'b1;
          idx_q <= '0;
          st_q  <= (c_cls == C_STORE) ? S_PUSH : S_IDLE;
        end
        S_PUSH: begin
          idx_q <= idx_q + 3'd1;
          if ((idx_q + 3'd1) == c_cnt) st_q <= S_DRAIN;
        end
        S_DRAIN: if (pop && fifo_cnt == CW'(1)) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != S_IDLE) || pend_q;
  assign error_o = err_q;
  assign rdata_o = (port_i == P_STAT) ? n_stat : head;
endmodule

// File: rtl/cop_port_chk.sv
module cop_port_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_a_i,
  input logic          sel_b_i,
  input logic          wr_i,
  input logic [1:0]    port_i,
  input logic          busy_o,
  input logic          pereq_o,
  input logic          error_o,
  input logic [CW-1:0] fifo_cnt
);
  logic op_wr;
  assign op_wr = sel_a_i && sel_b_i && wr_i && (port_i == 2'd0);

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !op_wr) |=> !busy_o); // R1
  AST_OPWR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_wr |=> busy_o); // R5
  AST_PEREQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pereq_o |-> busy_o); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(error_o) |-> $past(busy_o)); // R8
  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH)); // R9
endmodule

bind cop_port_unit cop_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .sel_a_i, .sel_b_i, .wr_i, .port_i,
  .busy_o, .pereq_o, .error_o, .fifo_cnt(fifo_cnt)
);

// File: tb/sim_cop_port_unit.sv
module sim_cop_port_unit;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_a = 0, sel_b = 0, wr = 0, rd = 0;
  logic [1:0] port = 0;
  logic [15:0] wdata = 0, rdata;
  logic busy, pereq, error;
  int n_chk = 0, n_fail = 0;

  always #(PER/2) clk = ~clk;

  cop_port_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .wr_i(wr), .rd_i(rd), .port_i(port), .wdata_i(wdata),
    .rdata_o(rdata), .busy_o(busy), .pereq_o(pereq), .error_o(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [1:0] p, input logic [15:0] d, input bit both = 1);
    @(negedge clk);
    sel_a = 1; sel_b = both; wr = 1; port = p; wdata = d;
    @(negedge clk);
    sel_a = 0; sel_b = 0; wr = 0;
  endtask

  task automatic rd_port(input logic [1:0] p, output logic [15:0] d);
    @(negedge clk);
    sel_a = 1; sel_b = 1; rd = 1; port = p;
    #1 d = rdata;
    @(negedge clk);
    sel_a = 0; sel_b = 0; rd = 0;
  endtask

  task automatic wait_sig(input int which, input logic val);
    for (int i = 0; i < 200; i++) begin
      if ((which == 0 ? busy : pereq) === val) return;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [15:0] s;
    chk(busy === 0 && pereq === 0 && error === 0, "R4 reset outputs", {busy, pereq, error}, 0);
    rd_port(2'd3, s);
    chk(s === 16'h0001, "R4 reset status", s, 16'h0001);
  endtask

  task automatic t_single_sel;
    wr_port(2'd0, 16'h0000, 0);
    @(negedge clk);
    chk(busy === 0, "R1 one select ignored", busy, 0);
  endtask

  task automatic t_plain_len;
    int n;
    logic [15:0] s;
    wr_port(2'd0, 16'h0030, 1);
    n = 1; // busy high on the negedge ending the write task
    while (busy === 1 && n < 100) begin @(negedge clk); if (busy === 1) n++; end
    chk(n == 5, "R5 plain busy length L+1", n, 5);
    rd_port(2'd3, s);
    chk(s === 16'h0001, "R4 plain status", s, 16'h0001);
  endtask

  task automatic t_load;
    logic [15:0] s;
    wr_port(2'd0, 16'h1012, 1);
    rd_port(2'd3, s);
    chk(s === 16'h0033, "R4 R3 load status", s, 16'h0033);
    repeat (5) @(negedge clk);
    chk(busy === 1 && pereq === 0, "R6 no pereq before pointer", {busy, pereq}, 2);
    wr_port(2'd2, 16'h0100, 1);
    chk(pereq === 1, "R6 pereq after pointer", pereq, 1);
    for (int i = 0; i < 3; i++) wr_port(2'd1, 16'(16'hA0 + i), 1);
    chk(pereq === 0, "R6 pereq drops after N words", pereq, 0);
    wait_sig(0, 0);
    chk(busy === 0, "R6 load completes", busy, 0);
  endtask

  task automatic t_store_overlap;
    logic [15:0] s, d;
    wr_port(2'd0, 16'h2022, 1);
    rd_port(2'd3, s);
    chk(s === 16'h0037, "R4 store status", s, 16'h0037);
    wr_port(2'd2, 16'h1230, 1);
    wait_sig(1, 1);
    chk(pereq === 1, "R7 results offered", pereq, 1);
    rd_port(2'd1, d);
    chk(d === 16'h1230, "R7 word 0", d, 16'h1230);
    wr_port(2'd0, 16'h0010, 1); // accepted while draining
    rd_port(2'd3, s);
    chk(s === 16'h0001, "R2 status tracks latest opcode", s, 16'h0001);
    rd_port(2'd1, d);
    chk(d === 16'h1231, "R7 word 1", d, 16'h1231);
    rd_port(2'd1, d);
    chk(d === 16'h1232, "R7 word 2", d, 16'h1232);
    chk(pereq === 0 && busy === 1, "R2 queued opcode keeps busy", {busy, pereq}, 2);
    wait_sig(0, 0);
    chk(busy === 0, "R2 queued opcode finished", busy, 0);
  endtask

  task automatic t_error;
    logic [15:0] s;
    wr_port(2'd0, 16'h0110, 1);
    chk(error === 0, "R8 no error before end", error, 0);
    wait_sig(0, 0);
    chk(error === 1, "R8 error raised", error, 1);
    wr_port(2'd0, 16'h0000, 1);
    wait_sig(0, 0);
    chk(error === 1, "R8 error held across opcode", error, 1);
    wr_port(2'd0, 16'h3000, 1);
    rd_port(2'd3, s);
    chk(s === 16'h0000, "R4 clear status", s, 0);
    chk(error === 0, "R8 error cleared", error, 0);
  endtask

  task automatic t_full_load;
    wr_port(2'd0, 16'h1003, 1);
    wr_port(2'd2, 16'h0000, 1);
    for (int i = 0; i < 4; i++) begin
      chk(pereq === 1, "R9 R6 room for word", pereq, 1);
      wr_port(2'd1, 16'(i), 1);
    end
    chk(pereq === 0, "R9 four words accepted", pereq, 0);
    wait_sig(0, 0);
    chk(busy === 0, "R3 four-word load done", busy, 0);
  endtask

  initial begin
    #(PER * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_sel();
    t_plain_len();
    t_load();
    t_store_overlap();
    t_error();
    t_full_load();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule